// File: doc/BRIEF.md
# Eight-Channel Trimmed PWM Lamp Dimmer

This block drives eight lamp dimming lines with pulse-width modulation. All channels share one free-running 8-bit frame counter and one common brightness value. Each channel then adds its own signed trim value to that common value and clamps the sum to 0..255. Lamps that differ slightly in brightness can be matched this way while a single value still dims the whole set.

A small register write port loads the common brightness, a control bit, a channel mask and the eight trim values. Each channel holds its duty in a shadow register. That shadow register is reloaded only when the frame counter wraps, so a register write never cuts a pulse short or adds one mid-frame.

The outputs are gated combinationally after the comparators. A line is driven only when all four of these hold: the external enable pin is high, the control enable bit is set, the channel's mask bit is set, and the fault input is low. If any of them fails, the line goes low at once.

Top module: `pwm_dim_array`

## Requirements
- R1: With all gating open, each output is high for exactly D of every 256 consecutive clocks, where D = clamp(common brightness + trim, 0, 255). The common brightness register is at address 0.
- R2: The trim for channel i is at address 8+i. It is an 8-bit two's-complement number, so 0xE2 lowers the duty by 30 and 0x14 raises it by 20.
- R3: A sum above 255 saturates to 255.
- R4: A sum below 0 saturates to 0, which gives a constant low output.
- R5: A duty of 0 keeps the line low for the whole frame. A duty of 255 keeps it high for 255 of the 256 counts.
- R6: Bit 0 of the control register (address 1) is ANDed with the enable pin. If either is low, all eight outputs are low in the same cycle, with no clock edge needed.
- R7: Bit i of the mask register (address 2) enables output i. A cleared bit holds that output low, while the other channels keep their duty.
- R8: While the fault input is high, every output is low in the same cycle. Normal pulses resume after it falls.
- R9: A new duty value takes effect only at the frame wrap, that is, when the counter goes from 255 to 0. A pulse in progress keeps its old length.
- R10: After reset all registers read as zero: brightness 0, trims 0, control bit 0 and mask 0. All outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address: 0 brightness, 1 control, 2 mask, 8..15 trims |
| wr_data | input | 8 | Register write data |
| en_pin | input | 1 | External enable |
| fault_in | input | 1 | Latched fault indication; high forces all outputs low |
| pwm_out | output | 8 | PWM dimming lines, bit i is channel i |

## Verification
Some properties are checked on every cycle: gating by the pin, the control bit, the mask and the fault; the rule that a shadow duty changes only on the cycle after the counter held 255; the direction of the trim relative to the common brightness; and a zero duty giving no pulse. The bench scenarios cover what only a whole frame can show. They count high cycles per 256-clock window for positive, negative and saturating trims. They also synchronise to a frame start and write a new brightness mid-pulse, to show that the running pulse keeps its old length.

// File: rtl/pwm_dim_pkg.sv
`timescale 1ns/1ps
package pwm_dim_pkg;
    localparam int NUM_CH   = 8;
    localparam int DUTY_W   = 8;
    localparam int CH_IDX_W = $clog2(NUM_CH);
    localparam int ADDR_W   = CH_IDX_W + 1;

    typedef logic [DUTY_W-1:0]        duty_t;
    typedef logic signed [DUTY_W-1:0] trim_t;

    typedef enum logic [ADDR_W-1:0] {
        ADR_LEVEL = ADDR_W'(0),
        ADR_CTRL  = ADDR_W'(1),
        ADR_MASK  = ADDR_W'(2)
    } reg_addr_e;

    typedef struct packed {
        duty_t             level;
        logic              run_bit;
        logic [NUM_CH-1:0] mask;
    } ctrl_s;

    localparam duty_t DUTY_MAX = {DUTY_W{1'b1}};

    function automatic duty_t sat_add(input duty_t base, input trim_t trim);
        logic signed [DUTY_W+1:0] sum;
        sum = $signed({2'b00, base}) + $signed({{2{trim[DUTY_W-1]}}, trim});
        if (sum < 0)
            return '0;
        else if (sum > $signed({2'b00, DUTY_MAX}))
            return DUTY_MAX;
        else
            return sum[DUTY_W-1:0];
    endfunction
endpackage

// File: rtl/dim_regfile.sv
`timescale 1ns/1ps
module dim_regfile
    import pwm_dim_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DUTY_W-1:0]        wr_data,
    output ctrl_s                    ctrl,
    output logic [NUM_CH-1:0][DUTY_W-1:0] trims
);
    ctrl_s ctrl_q;
    logic [NUM_CH-1:0][DUTY_W-1:0] trim_q;
    logic unused_wr_bits;

    assign unused_wr_bits = ^wr_data[DUTY_W-1:1];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en && !wr_addr[ADDR_W-1]) begin
            case (wr_addr)
                ADR_LEVEL: ctrl_q.level   <= wr_data;
                ADR_CTRL:  ctrl_q.run_bit <= wr_data[0];
                ADR_MASK:  ctrl_q.mask    <= wr_data[NUM_CH-1:0];
                default:   ;
            endcase
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_trim
        always_ff @(posedge clk) begin
            if (rst)
                trim_q[g] <= '0;
            else if (wr_en && wr_addr[ADDR_W-1] && wr_addr[CH_IDX_W-1:0] == CH_IDX_W'(g))
                trim_q[g] <= wr_data;
        end
    end

    assign ctrl  = ctrl_q;
    assign trims = trim_q;
endmodule

// File: rtl/dim_frame_ctr.sv
`timescale 1ns/1ps
module dim_frame_ctr
    import pwm_dim_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output duty_t count,
    output logic  wrap
);
    duty_t cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    assign count = cnt_q;
    assign wrap  = (cnt_q == DUTY_MAX);
endmodule

// File: rtl/dim_duty_calc.sv
`timescale 1ns/1ps
module dim_duty_calc
    import pwm_dim_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  duty_t                         level,
    input  logic [NUM_CH-1:0][DUTY_W-1:0] trims,
    output logic [NUM_CH-1:0][DUTY_W-1:0] duty
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_calc
        assign duty[g] = sat_add(level, trim_t'(trims[g]));

        // R2 R3 R4: a non-negative trim never lowers the duty, a negative one never raises it
        a_r2_trim_up: assert property (@(posedge clk) disable iff (rst)
            !trims[g][DUTY_W-1] |-> duty[g] >= level);
        a_r2_trim_down: assert property (@(posedge clk) disable iff (rst)
            trims[g][DUTY_W-1] |-> duty[g] < level || (level == '0 && duty[g] == '0));
    end
endmodule

// File: rtl/dim_channel.sv
`timescale 1ns/1ps
module dim_channel
    import pwm_dim_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  duty_t count,
    input  logic  wrap,
    input  duty_t duty_next,
    input  logic  gate,
    output logic  pwm
);
    duty_t shadow_q;
    logic  raw;

    always_ff @(posedge clk) begin
        if (rst)       shadow_q <= '0;
        else if (wrap) shadow_q <= duty_next;
    end

    assign raw = (count < shadow_q);
    assign pwm = raw & gate;

    // R9: the shadow duty only changes right after the counter held its top value
    a_r9_load_at_wrap: assert property (@(posedge clk) disable iff (rst)
        !$stable(shadow_q) |-> $past(count) == DUTY_MAX);

    // R5: zero duty produces no pulse
    a_r5_zero_duty: assert property (@(posedge clk) disable iff (rst)
        shadow_q == '0 |-> !pwm);
endmodule

// File: rtl/pwm_dim_array.sv
`timescale 1ns/1ps
module pwm_dim_array
    import pwm_dim_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DUTY_W-1:0] wr_data,
    input  logic              en_pin,
    input  logic              fault_in,
    output logic [NUM_CH-1:0] pwm_out
);
    ctrl_s                         ctrl;
    logic [NUM_CH-1:0][DUTY_W-1:0] trims;
    logic [NUM_CH-1:0][DUTY_W-1:0] duty;
    duty_t                         count;
    logic                          wrap;
    logic                          run_all;

    dim_regfile u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ctrl(ctrl), .trims(trims)
    );

    dim_frame_ctr u_ctr (
        .clk(clk), .rst(rst), .count(count), .wrap(wrap)
    );

    dim_duty_calc u_calc (
        .clk(clk), .rst(rst), .level(ctrl.level), .trims(trims), .duty(duty)
    );

    assign run_all = en_pin & ctrl.run_bit & ~fault_in;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dim_channel u_ch (
            .clk(clk), .rst(rst), .count(count), .wrap(wrap),
            .duty_next(duty[g]), .gate(run_all & ctrl.mask[g]), .pwm(pwm_out[g])
        );
    end

    // R6: pin and control bit both needed
    a_r6_global_gate: assert property (@(posedge clk) disable iff (rst)
        !(en_pin && ctrl.run_bit) |-> pwm_out == '0);
    // R7: masked channels stay low
    a_r7_mask: assert property (@(posedge clk) disable iff (rst)
        (pwm_out & ~ctrl.mask) == '0);
    // R8: fault forces all low
    a_r8_fault: assert property (@(posedge clk) disable iff (rst)
        fault_in |-> pwm_out == '0);
endmodule

// File: tb/test_pwm_dim_array.sv
`timescale 1ns/1ps
module test_pwm_dim_array;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       en_pin = 1'b0;
    logic       fault_in = 1'b0;
    logic [7:0] pwm_out;

    int n_tests = 0;
    int n_fail  = 0;
    int hi_cnt [8];

    always #5 clk = ~clk;

    pwm_dim_array i_pwm_dim_array (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .en_pin(en_pin), .fault_in(fault_in), .pwm_out(pwm_out)
    );

    function automatic int exp_duty(input int level, input int trim8);
        int t, s;
        t = (trim8 >= 128) ? trim8 - 256 : trim8;
        s = level + t;
        if (s < 0) s = 0;
        if (s > 255) s = 255;
        return s;
    endfunction

    task automatic check(input string req, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(addr); wr_data = 8'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic measure();
        repeat (300) @(negedge clk);
        for (int c = 0; c < 8; c++) hi_cnt[c] = 0;
        for (int k = 0; k < 256; k++) begin
            @(negedge clk);
            for (int c = 0; c < 8; c++) if (pwm_out[c]) hi_cnt[c]++;
        end
    endtask

    task automatic t_reset();
        measure();
        for (int c = 0; c < 8; c++) check("R10 reset low", hi_cnt[c], 0);
    endtask

    task automatic t_trim();
        int trims [8] = '{0, 20, 8'hE2, 5, 8'h80, 127, 8'hFF, 8'h9C};
        en_pin = 1'b1;
        wr(1, 1); wr(2, 8'hFF);
        for (int c = 0; c < 8; c++) wr(8 + c, trims[c]);
        wr(0, 100);
        measure();
        for (int c = 0; c < 8; c++) check("R1 R2 R4 level 100", hi_cnt[c], exp_duty(100, trims[c]));
        wr(0, 200);
        measure();
        for (int c = 0; c < 8; c++) check("R1 R2 R3 level 200", hi_cnt[c], exp_duty(200, trims[c]));
    endtask

    task automatic t_extremes();
        for (int c = 0; c < 8; c++) wr(8 + c, 0);
        wr(0, 0);
        measure();
        for (int c = 0; c < 8; c++) check("R5 zero duty", hi_cnt[c], 0);
        wr(0, 255);
        measure();
        for (int c = 0; c < 8; c++) check("R5 full duty", hi_cnt[c], 255);
    endtask

    task automatic t_mask();
        wr(0, 128); wr(2, 8'h55);
        measure();
        for (int c = 0; c < 8; c++) check("R7 mask", hi_cnt[c], (c % 2 == 0) ? 128 : 0);
        wr(2, 8'hFF);
    endtask

    task automatic t_global();
        measure();
        @(posedge pwm_out[0]);
        @(negedge clk);
        en_pin = 1'b0; #1;
        check("R6 pin low same cycle", int'(pwm_out), 0);
        measure();
        for (int c = 0; c < 8; c++) check("R6 pin low frame", hi_cnt[c], 0);
        en_pin = 1'b1; wr(1, 0);
        measure();
        for (int c = 0; c < 8; c++) check("R6 ctrl bit low", hi_cnt[c], 0);
        wr(1, 1);
        measure();
        check("R6 restored", hi_cnt[3], 128);
    endtask

    task automatic t_fault();
        @(posedge pwm_out[0]);
        @(negedge clk);
        fault_in = 1'b1; #1;
        check("R8 fault same cycle", int'(pwm_out), 0);
        measure();
        for (int c = 0; c < 8; c++) check("R8 fault frame", hi_cnt[c], 0);
        fault_in = 1'b0;
        measure();
        check("R8 resume", hi_cnt[5], 128);
    endtask

    task automatic t_wrap_load();
        @(posedge pwm_out[0]);
        repeat (60) @(negedge clk);
        wr(0, 20);
        check("R9 pulse kept", int'(pwm_out[0]), 1);
        repeat (40) @(negedge clk);
        check("R9 pulse still old", int'(pwm_out[0]), 1);
        measure();
        check("R9 new duty", hi_cnt[0], 20);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_trim();
        t_extremes();
        t_mask();
        t_global();
        t_fault();
        t_wrap_load();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule